// File: doc/BRIEF.md
# Character Display Bus Host with Busy Polling

This block sits between an on-chip request queue and the parallel bus of a character display controller. Each request carries a register-select bit, a direction bit and a data byte. Requests arrive over a valid/ready handshake. For every accepted request the block first issues status reads (register select low, read direction) and repeats them until the busy bit in the returned byte is clear. Only then does it run the requested instruction write, data write or data read. It never waits a fixed worst-case delay: a short command is followed as soon as the display reports idle, and a slow command such as clear or home is polled for as long as it takes.

Every bus cycle follows the same timing. Register select and direction settle a programmable number of clocks before the enable strobe rises. The strobe stays high for a programmable width. Read data is captured on the last clock of the strobe. A programmable hold interval follows before the cycle ends. The data bus is split into output, output-enable and input so that the pad ring can build the tristate buffer. The output enable is raised only for write cycles. The seven low bits of each status read are kept as the display's current address counter. A clock-count limit on polling aborts a request whose busy bit never clears, raises an error flag and returns the block to idle. The limit should be set above the longest execution time of the display, about 1.53 ms.

Top module: `chardisp_host`

## Requirements
- R1: After reset `req_ready` is 1, `lcd_en` is 0, `db_oe` is 0, `busy_timeout` is 0, `rsp_valid` is 0 and `addr_cnt` is 0. `req_ready` is 1 only while no request is in progress.
- R2: For each accepted request the block performs status reads (`lcd_rs`=0, `lcd_rw`=1) until one returns bit 7 of `db_in` equal to 0. With N busy replies, exactly N+1 status reads precede the transfer.
- R3: The transfer cycle uses `lcd_rs` = `req_rs` and `lcd_rw` = `req_rd`. A write (`req_rd`=0) presents `req_data` on `db_out`. Exactly one transfer cycle occurs per completed request.
- R4: In every bus cycle `lcd_rs` and `lcd_rw` are stable for at least SETUP_CLKS clocks before `lcd_en` rises. `lcd_en` stays high for exactly EN_CLKS clocks, and `lcd_rs`, `lcd_rw` and `db_out` do not change while it is high.
- R5: `db_oe` is 1 during the strobe of every write cycle and is 0 whenever `lcd_rw` is 1.
- R6: For a data read (`req_rs`=1, `req_rd`=1), the `db_in` value present on the last clock of the strobe is returned on `rsp_data` with `rsp_valid` high for exactly one clock.
- R7: `addr_cnt` holds bits 6..0 of the most recent status read.
- R8: If a status read returns busy once TIMEOUT_CLKS clocks have passed in polling since acceptance, no transfer is made, `busy_timeout` goes to 1 and the block returns to idle. With a bus-cycle period P = 1+SETUP_CLKS+EN_CLKS+HOLD_CLKS, this happens after ceil(TIMEOUT_CLKS/P) status reads. `busy_timeout` clears when the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_rs | input | 1 | Register select of the request (0 instruction, 1 data) |
| req_rd | input | 1 | Direction of the request (1 read) |
| req_data | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-clock pulse with read data |
| rsp_data | output | 8 | Byte returned by a data read |
| addr_cnt | output | 7 | Address counter from the last status read |
| busy_timeout | output | 1 | Last request aborted on busy timeout |
| lcd_rs | output | 1 | Display register select |
| lcd_rw | output | 1 | Display direction (1 read) |
| lcd_en | output | 1 | Display enable strobe |
| db_out | output | 8 | Data bus value to drive |
| db_oe | output | 1 | Drive enable for the data bus |
| db_in | input | 8 | Data bus value from the pads |

## Verification
If the poll loop goes wrong, the display sees a transfer strobe while the last status byte still showed busy, or it sees the wrong number of status reads. Either shows on the bus within one bus-cycle period of the faulty decision. A bad phase counter shows up in the first strobe as a short setup or a wrong enable width. A bad direction latch shows up as `db_oe` high during a read. A stale capture register shows up at once as a wrong `addr_cnt` or `rsp_data`. A broken timeout shows up as a poll count different from ceil(TIMEOUT_CLKS/P), or as a missing error flag when `req_ready` returns.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } bus_phase_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_POLL_GO,
    SQ_POLL_WAIT,
    SQ_XFER_GO,
    SQ_XFER_WAIT
  } seq_state_e;

  typedef struct packed {
    logic       rs;
    logic       rd;
    logic [7:0] data;
  } host_req_t;

  localparam int STAT_BUSY_BIT = 7;

  // clocks spent inside one bus cycle after its start edge
  function automatic int unsigned cycle_clks(int unsigned s, int unsigned e, int unsigned h);
    return s + e + h;
  endfunction

  // clocks between two successive status-read starts
  function automatic int unsigned poll_period(int unsigned s, int unsigned e, int unsigned h);
    return 1 + cycle_clks(s, e, h);
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic logic stat_is_busy(logic [7:0] b);
    return b[STAT_BUSY_BIT];
  endfunction

  function automatic logic [6:0] stat_addr(logic [7:0] b);
    return b[6:0];
  endfunction

endpackage

// File: rtl/chardisp_buscycle.sv
module chardisp_buscycle
  import chardisp_pkg::*;
#(
  parameter int unsigned SETUP_CLKS = 4,
  parameter int unsigned EN_CLKS    = 8,
  parameter int unsigned HOLD_CLKS  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_rs,
  input  logic       start_rw,
  input  logic [7:0] start_wdata,
  input  logic [7:0] db_in,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_en,
  output logic [7:0] db_out,
  output logic       db_oe,
  output logic       cyc_busy,
  output logic       cyc_done,
  output logic [7:0] cyc_rdata
);

  localparam int unsigned LONGEST = max3(SETUP_CLKS, EN_CLKS, HOLD_CLKS);
  localparam int unsigned CW      = (LONGEST < 2) ? 1 : $clog2(LONGEST);
  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CLKS - 1);
  localparam logic [CW-1:0] EN_LAST    = CW'(EN_CLKS - 1);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CLKS - 1);

  bus_phase_e    phase;
  logic [CW-1:0] cnt;
  logic          rs_q, rw_q;
  logic [7:0]    wdata_q;
  logic [7:0]    rdata_q;
  logic          phase_end;
  logic          strobe_last;

  assign phase_end   = (cnt == '0);
  assign strobe_last = (phase == PH_STROBE) && phase_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      rs_q    <= 1'b0;
      rw_q    <= 1'b1;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            rs_q    <= start_rs;
            rw_q    <= start_rw;
            wdata_q <= start_wdata;
            phase   <= PH_SETUP;
            cnt     <= SETUP_LAST;
          end
        end
        PH_SETUP: begin
          if (phase_end) begin
            phase <= PH_STROBE;
            cnt   <= EN_LAST;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (phase_end) begin
            phase <= PH_HOLD;
            cnt   <= HOLD_LAST;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HOLD: begin
          if (phase_end) begin
            phase <= PH_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
      if (strobe_last) begin
        rdata_q <= db_in;
      end
    end
  end

  assign lcd_rs    = rs_q;
  assign lcd_rw    = rw_q;
  assign lcd_en    = (phase == PH_STROBE);
  assign db_out    = wdata_q;
  assign db_oe     = (phase != PH_IDLE) && !rw_q;
  assign cyc_busy  = (phase != PH_IDLE);
  assign cyc_done  = (phase == PH_HOLD) && phase_end;
  assign cyc_rdata = rdata_q;

  AST_STROBE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_en) |-> $stable(lcd_rs) && $stable(lcd_rw)); // R4

  AST_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_en && $past(lcd_en)) |-> $stable(lcd_rs) && $stable(lcd_rw) && $stable(db_out)); // R4

  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_rw |-> !db_oe); // R5

endmodule

// File: rtl/chardisp_waitcnt.sv
module chardisp_waitcnt #(
  parameter int unsigned LIMIT = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);

  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (run && (cnt < LAST)) begin
      cnt <= cnt + 1'b1;
    end
  end

  // the current clock is counted as well: expired once cnt+1 reaches LIMIT
  assign expired = (cnt >= LAST);

endmodule

// File: rtl/chardisp_seq.sv
module chardisp_seq
  import chardisp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  host_req_t  req_in,
  output logic       req_ready,
  input  logic       cyc_busy,
  input  logic       cyc_done,
  input  logic [7:0] cyc_rdata,
  output logic       cyc_start,
  output logic       cyc_rs,
  output logic       cyc_rw,
  output logic [7:0] cyc_wdata,
  input  logic       wait_expired,
  output logic       wait_clr,
  output logic       wait_run,
  output logic [6:0] addr_cnt,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  output logic       busy_timeout
);

  seq_state_e state, state_nx;
  host_req_t  req_q;
  logic       accept;
  logic       poll_done;
  logic       stat_busy;
  logic       timeout_evt;
  logic       xfer_start;
  logic       xfer_done;

  assign req_ready   = (state == SQ_IDLE);
  assign accept      = req_ready && req_valid;
  assign poll_done   = (state == SQ_POLL_WAIT) && cyc_done;
  assign stat_busy   = stat_is_busy(cyc_rdata);
  assign timeout_evt = poll_done && stat_busy && wait_expired;
  assign xfer_start  = (state == SQ_XFER_GO);
  assign xfer_done   = (state == SQ_XFER_WAIT) && cyc_done;

  assign cyc_start = (state == SQ_POLL_GO) || xfer_start;
  assign cyc_rs    = xfer_start ? req_q.rs : 1'b0;
  assign cyc_rw    = xfer_start ? req_q.rd : 1'b1;
  assign cyc_wdata = req_q.data;

  assign wait_clr = accept;
  assign wait_run = (state == SQ_POLL_GO) || (state == SQ_POLL_WAIT);

  always_comb begin
    state_nx = state;
    unique case (state)
      SQ_IDLE:      if (accept) state_nx = SQ_POLL_GO;
      SQ_POLL_GO:   state_nx = SQ_POLL_WAIT;
      SQ_POLL_WAIT: begin
        if (poll_done) begin
          if (!stat_busy)       state_nx = SQ_XFER_GO;
          else if (timeout_evt) state_nx = SQ_IDLE;
          else                  state_nx = SQ_POLL_GO;
        end
      end
      SQ_XFER_GO:   state_nx = SQ_XFER_WAIT;
      SQ_XFER_WAIT: if (cyc_done) state_nx = SQ_IDLE;
      default:      state_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= SQ_IDLE;
      req_q        <= '0;
      addr_cnt     <= '0;
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      busy_timeout <= 1'b0;
    end else begin
      state     <= state_nx;
      rsp_valid <= xfer_done && req_q.rd;
      if (accept) begin
        req_q        <= req_in;
        busy_timeout <= 1'b0;
      end else if (timeout_evt) begin
        busy_timeout <= 1'b1;
      end
      if (poll_done) begin
        addr_cnt <= stat_addr(cyc_rdata);
      end
      if (xfer_done && req_q.rd) begin
        rsp_data <= cyc_rdata;
      end
    end
  end

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cyc_busy); // R1

  AST_XFER_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> !cyc_rdata[STAT_BUSY_BIT]); // R2

  AST_TIMEOUT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> req_ready && busy_timeout); // R8

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R6

endmodule

// File: rtl/chardisp_host.sv
module chardisp_host
  import chardisp_pkg::*;
#(
  parameter int unsigned SETUP_CLKS   = 4,
  parameter int unsigned EN_CLKS      = 8,
  parameter int unsigned HOLD_CLKS    = 2,
  parameter int unsigned TIMEOUT_CLKS = 200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_rs,
  input  logic       req_rd,
  input  logic [7:0] req_data,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  output logic [6:0] addr_cnt,
  output logic       busy_timeout,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_en,
  output logic [7:0] db_out,
  output logic       db_oe,
  input  logic [7:0] db_in
);

  host_req_t  req_bundle;
  logic       cyc_start, cyc_rs, cyc_rw, cyc_busy, cyc_done;
  logic [7:0] cyc_wdata, cyc_rdata;
  logic       wait_clr, wait_run, wait_expired;

  assign req_bundle = '{rs: req_rs, rd: req_rd, data: req_data};

  chardisp_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_in       (req_bundle),
    .req_ready    (req_ready),
    .cyc_busy     (cyc_busy),
    .cyc_done     (cyc_done),
    .cyc_rdata    (cyc_rdata),
    .cyc_start    (cyc_start),
    .cyc_rs       (cyc_rs),
    .cyc_rw       (cyc_rw),
    .cyc_wdata    (cyc_wdata),
    .wait_expired (wait_expired),
    .wait_clr     (wait_clr),
    .wait_run     (wait_run),
    .addr_cnt     (addr_cnt),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .busy_timeout (busy_timeout)
  );

  chardisp_buscycle #(
    .SETUP_CLKS (SETUP_CLKS),
    .EN_CLKS    (EN_CLKS),
    .HOLD_CLKS  (HOLD_CLKS)
  ) u_bus (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (cyc_start),
    .start_rs    (cyc_rs),
    .start_rw    (cyc_rw),
    .start_wdata (cyc_wdata),
    .db_in       (db_in),
    .lcd_rs      (lcd_rs),
    .lcd_rw      (lcd_rw),
    .lcd_en      (lcd_en),
    .db_out      (db_out),
    .db_oe       (db_oe),
    .cyc_busy    (cyc_busy),
    .cyc_done    (cyc_done),
    .cyc_rdata   (cyc_rdata)
  );

  chardisp_waitcnt #(
    .LIMIT (TIMEOUT_CLKS)
  ) u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (wait_clr),
    .run     (wait_run),
    .expired (wait_expired)
  );

endmodule

// File: tb/test_chardisp_host.sv
module test_chardisp_host;

  localparam int S  = 2;
  localparam int E  = 3;
  localparam int H  = 1;
  localparam int TO = 50;
  localparam int PERIOD_POLL = 1 + S + E + H;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_rs = 1'b0;
  logic       req_rd = 1'b0;
  logic [7:0] req_data = '0;
  logic       req_ready, rsp_valid, busy_timeout;
  logic [7:0] rsp_data, db_out, db_in;
  logic [6:0] addr_cnt;
  logic       lcd_rs, lcd_rw, lcd_en, db_oe;

  always #4 clk = ~clk;

  chardisp_host #(
    .SETUP_CLKS(S), .EN_CLKS(E), .HOLD_CLKS(H), .TIMEOUT_CLKS(TO)
  ) i_chardisp_host (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rs(req_rs), .req_rd(req_rd), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .addr_cnt(addr_cnt),
    .busy_timeout(busy_timeout), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
    .lcd_en(lcd_en), .db_out(db_out), .db_oe(db_oe), .db_in(db_in)
  );

  // display model
  int         m_busy_left = 0;
  bit         m_forever = 0;
  logic [6:0] m_ac = '0;
  logic [7:0] m_rdbyte = '0;
  logic       m_busy;
  assign m_busy = m_forever || (m_busy_left != 0);
  always_comb db_in = !lcd_rs ? {m_busy, m_ac} : m_rdbyte;

  // bus monitor, samples at the falling clock edge
  int n_status = 0, n_write = 0, n_dread = 0, n_rsp = 0;
  int en_bad = 0, setup_bad = 0, oe_bad = 0, n_strobes = 0;
  int setup_run = 0, en_cnt = 0;
  logic prev_en = 1'b0, prev_rs = 1'b0, prev_rw = 1'b1;
  logic       last_w_rs = 1'b0;
  logic [7:0] last_w_data = '0, last_rsp = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (lcd_rs !== prev_rs || lcd_rw !== prev_rw) setup_run = 0;
      else if (setup_run < 1000) setup_run++;
      if (lcd_en && !prev_en) begin
        n_strobes++;
        if (setup_run < S) setup_bad++;
        en_cnt = 0;
      end
      if (lcd_en) en_cnt++;
      if (!lcd_en && prev_en) begin
        if (en_cnt != E) en_bad++;
        if (!lcd_rs && lcd_rw) begin
          n_status++;
          if (!m_forever && m_busy_left != 0) m_busy_left--;
        end else if (!lcd_rw) begin
          n_write++;
          last_w_rs = lcd_rs;
          last_w_data = db_out;
        end else begin
          n_dread++;
        end
      end
      if (lcd_rw && db_oe) oe_bad++;
      if (lcd_en && !lcd_rw && !db_oe) oe_bad++;
      if (rsp_valid) begin
        n_rsp++;
        last_rsp = rsp_data;
      end
      prev_en = lcd_en;
      prev_rs = lcd_rs;
      prev_rw = lcd_rw;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // runs one request; returns the number of status reads and transfers seen
  task automatic run_req(input logic rs, input logic rd, input logic [7:0] data,
                         input int busy_n, input bit forever_busy,
                         input logic [6:0] ac, input logic [7:0] rb,
                         output int d_stat, output int d_wr, output int d_rd, output int d_rsp,
                         output bit ready_low_seen);
    int s0, w0, r0, p0;
    m_busy_left = busy_n;
    m_forever = forever_busy;
    m_ac = ac;
    m_rdbyte = rb;
    s0 = n_status; w0 = n_write; r0 = n_dread; p0 = n_rsp;
    req_rs = rs; req_rd = rd; req_data = data; req_valid = 1'b1;
    tick();
    req_valid = 1'b0;
    ready_low_seen = !req_ready;
    for (int i = 0; i < 5000 && !req_ready; i++) tick();
    tick();
    m_forever = 0;
    d_stat = n_status - s0;
    d_wr = n_write - w0;
    d_rd = n_dread - r0;
    d_rsp = n_rsp - p0;
  endtask

  // rs, rd, data, busy replies, address counter, read byte
  localparam logic [28:0] VEC [6] = '{
    {1'b0, 1'b0, 8'h01, 4'd3, 7'h00, 8'h00},
    {1'b1, 1'b0, 8'h41, 4'd0, 7'h05, 8'h00},
    {1'b1, 1'b1, 8'h00, 4'd1, 7'h06, 8'hA5},
    {1'b0, 1'b0, 8'h80, 4'd0, 7'h7F, 8'h00},
    {1'b1, 1'b0, 8'hFF, 4'd5, 7'h2A, 8'h00},
    {1'b1, 1'b1, 8'h00, 4'd0, 7'h40, 8'h3C}
  };

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
      summary();
    end
  end

  initial begin
    int ds, dw, dr, dp, exp_polls;
    bit rl;
    repeat (4) tick();
    // R1 reset state
    chk(req_ready === 1'b1, "R1 ready after reset", req_ready, 1);
    chk(lcd_en === 1'b0 && db_oe === 1'b0, "R1 bus idle after reset", {lcd_en, db_oe}, 0);
    chk(busy_timeout === 1'b0 && rsp_valid === 1'b0 && addr_cnt === 7'h0,
        "R1 flags after reset", {busy_timeout, rsp_valid, addr_cnt}, 0);
    rst_n = 1'b1;
    tick();

    for (int v = 0; v < 6; v++) begin
      logic       vrs, vrd;
      logic [7:0] vd, vrb;
      logic [3:0] vb;
      logic [6:0] vac;
      {vrs, vrd, vd, vb, vac, vrb} = VEC[v];
      run_req(vrs, vrd, vd, int'(vb), 1'b0, vac, vrb, ds, dw, dr, dp, rl);
      if (v == 0) chk(rl, "R1 ready low while busy", req_ready, 0);
      chk(ds == int'(vb) + 1, "R2 status read count", ds, int'(vb) + 1);
      chk(addr_cnt === vac, "R7 address counter", addr_cnt, vac);
      chk(busy_timeout === 1'b0, "R8 no timeout", busy_timeout, 0);
      if (!vrd) begin
        chk(dw == 1 && dr == 0, "R3 one write", {dw[15:0], dr[15:0]}, 32'h10000);
        chk(last_w_rs === vrs && last_w_data === vd, "R3 write fields",
            {last_w_rs, last_w_data}, {vrs, vd});
      end else begin
        chk(dr == 1 && dw == 0, "R3 one data read", {dr[15:0], dw[15:0]}, 32'h10000);
        chk(dp == 1 && last_rsp === vrb, "R6 read response", {dp[7:0], last_rsp}, {8'd1, vrb});
      end
    end

    // R8 busy never clears: ceil(TO/period) polls then error, no transfer
    exp_polls = (TO + PERIOD_POLL - 1) / PERIOD_POLL;
    run_req(1'b1, 1'b0, 8'h33, 0, 1'b1, 7'h11, 8'h00, ds, dw, dr, dp, rl);
    chk(ds == exp_polls, "R8 polls before timeout", ds, exp_polls);
    chk(dw == 0 && dr == 0, "R8 no transfer after timeout", dw + dr, 0);
    chk(busy_timeout === 1'b1 && req_ready === 1'b1, "R8 error flag and idle",
        {busy_timeout, req_ready}, 2'b11);
    chk(addr_cnt === 7'h11, "R7 address from busy read", addr_cnt, 7'h11);

    // R8 flag clears on next accepted request
    run_req(1'b0, 1'b0, 8'h0C, 2, 1'b0, 7'h12, 8'h00, ds, dw, dr, dp, rl);
    chk(busy_timeout === 1'b0, "R8 flag cleared", busy_timeout, 0);
    chk(dw == 1 && last_w_data === 8'h0C, "R3 write after timeout", last_w_data, 8'h0C);

    // R4 / R5 timing collected over every strobe
    chk(n_strobes > 20 && setup_bad == 0, "R4 setup before strobe", setup_bad, 0);
    chk(en_bad == 0, "R4 strobe width", en_bad, 0);
    chk(oe_bad == 0, "R5 drive enable", oe_bad, 0);

    done = 1;
    summary();
  end

endmodule